// File: doc/BRIEF.md
# Microcoded Single-Bus Accumulator Processor

This block is a small accumulator processor. It has a data section and a control section. Every transfer inside the data section uses one shared 16-bit bus. Six registers sit on that bus:

- program counter
- accumulator
- instruction register
- operand register
- buffer register
- memory address register

An ALU and a word-addressed RAM also hang on the bus. The control section holds a microcode ROM, a micro-program counter and a field decoder. The decoder picks exactly one bus driver per step and raises the load enables, the ALU function and the RAM write strobe.

An instruction word carries a 3-bit opcode in bits 15:13 and a 13-bit address field in bits 12:0. There are eight instructions. They cover stop, unconditional and zero-conditional jumps, add, subtract, load, store and no-operation.

A program is written into the RAM through a load port while reset is held. Execution starts at address 0 when reset is released. It runs until a stop instruction, after which the processor sits frozen and flags `halted`.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, on each clock edge the program counter, the accumulator and the micro-program counter clear to zero, and `halted` reads 0.
- R2: Opcode encoding in word bits 15:13 is: stop=0, jump=1, jump-if-zero=2, add=3, subtract=4, load=5, store=6, no-op=7. Bits 12:0 are the address field.
- R3: Every instruction takes 4 fetch/decode cycles, and the program counter rises by 1 in the third cycle. The extra execute cycles are: jump 1, jump-if-zero 1, add 3, subtract 3, load 2, store 2, no-op 1. The stop instruction raises `halted` after its 4 fetch/decode cycles.
- R4: Jump loads the program counter with the address field.
- R5: Jump-if-zero loads the program counter with the address field only when the accumulator is zero. Otherwise the program counter keeps its incremented value.
- R6: Add and subtract use RAM[address] as the second operand. They write the sum or difference back to the accumulator, wrapping at 16 bits.
- R7: Load copies RAM[address] into the accumulator. Store writes the accumulator into RAM[address], so the value can be read back later by a load.
- R8: No-op changes neither the accumulator nor the RAM. Only the program counter advances.
- R9: After a stop, `halted` stays 1 and the program counter and the accumulator hold their values until reset.
- R10: In every cycle at most one source drives the bus. A RAM write always carries the accumulator value.
- R11: Only the low RAM_AW bits of an address select a RAM word. The load port writes RAM only while reset is high and has no effect while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Program-load write enable, honoured only in reset |
| load_addr | input | RAM_AW | Program-load word address |
| load_data | input | 16 | Program-load word |
| acc_q | output | 16 | Accumulator value |
| pc_q | output | 16 | Program counter value |
| halted | output | 1 | High once a stop instruction has been decoded |

## Verification
Several properties are checked on every cycle:

- at most one bus driver is selected
- a store puts the accumulator on the bus
- the program counter steps by one on increment steps
- a not-taken conditional jump leaves the program counter alone
- the halted state is sticky, with the registers frozen

Some behaviour can only be shown by whole programs. This covers the exact cycle count of each instruction's microroutine and the arithmetic wrap. It also covers a store followed by a load-back, address-field masking, and a load-port write attempted while running. The bench runs directed and random straight-line programs and compares the final accumulator, program counter and cycle count against an instruction-level model.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 3;
    localparam int AFLD_W = WORD_W - OPC_W;
    localparam int UPC_W  = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT = 3'd0,
        OP_JMP  = 3'd1,
        OP_JZ   = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_LD   = 3'd5,
        OP_ST   = 3'd6,
        OP_NOP  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        BS_NONE = 3'd0,
        BS_PC   = 3'd1,
        BS_ACC  = 3'd2,
        BS_IRA  = 3'd3,
        BS_BUF  = 3'd4,
        BS_ALU  = 3'd5,
        BS_RAM  = 3'd6
    } bus_src_e;

    localparam int NUM_SRC = 7;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_op_e;

    typedef enum logic [1:0] {
        SQ_NEXT     = 2'd0,
        SQ_FETCH    = 2'd1,
        SQ_DISPATCH = 2'd2,
        SQ_HOLD     = 2'd3
    } seq_e;

    typedef struct packed {
        bus_src_e src;
        logic     ld_mar;
        logic     ld_buf;
        logic     ld_ir;
        logic     ld_arg;
        logic     ld_acc;
        logic     ld_pc;
        logic     ld_pcz;
        logic     pc_inc;
        logic     ram_we;
        alu_op_e  alu;
        seq_e     seq;
    } uword_t;

    // microroutine entry points
    localparam logic [UPC_W-1:0] U_HALT = 5'd4;
    localparam logic [UPC_W-1:0] U_JMP  = 5'd5;
    localparam logic [UPC_W-1:0] U_JZ   = 5'd6;
    localparam logic [UPC_W-1:0] U_ADD  = 5'd7;
    localparam logic [UPC_W-1:0] U_SUB  = 5'd10;
    localparam logic [UPC_W-1:0] U_LD   = 5'd13;
    localparam logic [UPC_W-1:0] U_ST   = 5'd15;
    localparam logic [UPC_W-1:0] U_NOP  = 5'd17;

    function automatic logic [UPC_W-1:0] dispatch_base(opcode_e op);
        case (op)
            OP_HALT: return U_HALT;
            OP_JMP:  return U_JMP;
            OP_JZ:   return U_JZ;
            OP_ADD:  return U_ADD;
            OP_SUB:  return U_SUB;
            OP_LD:   return U_LD;
            OP_ST:   return U_ST;
            default: return U_NOP;
        endcase
    endfunction

    function automatic uword_t ucode_word(logic [UPC_W-1:0] a);
        uword_t w;
        w     = '0;
        w.seq = SQ_NEXT;
        case (a)
            5'd0:  begin w.src = BS_PC;  w.ld_mar = 1'b1; end
            5'd1:  begin w.src = BS_RAM; w.ld_buf = 1'b1; end
            5'd2:  begin w.src = BS_BUF; w.ld_ir = 1'b1; w.pc_inc = 1'b1; end
            5'd3:  begin w.seq = SQ_DISPATCH; end
            5'd4:  begin w.seq = SQ_HOLD; end
            5'd5:  begin w.src = BS_IRA; w.ld_pc = 1'b1; w.seq = SQ_FETCH; end
            5'd6:  begin w.src = BS_IRA; w.ld_pcz = 1'b1; w.seq = SQ_FETCH; end
            5'd7:  begin w.src = BS_IRA; w.ld_mar = 1'b1; end
            5'd8:  begin w.src = BS_RAM; w.ld_arg = 1'b1; end
            5'd9:  begin w.src = BS_ALU; w.alu = ALU_ADD; w.ld_acc = 1'b1; w.seq = SQ_FETCH; end
            5'd10: begin w.src = BS_IRA; w.ld_mar = 1'b1; end
            5'd11: begin w.src = BS_RAM; w.ld_arg = 1'b1; end
            5'd12: begin w.src = BS_ALU; w.alu = ALU_SUB; w.ld_acc = 1'b1; w.seq = SQ_FETCH; end
            5'd13: begin w.src = BS_IRA; w.ld_mar = 1'b1; end
            5'd14: begin w.src = BS_RAM; w.ld_acc = 1'b1; w.seq = SQ_FETCH; end
            5'd15: begin w.src = BS_IRA; w.ld_mar = 1'b1; end
            5'd16: begin w.src = BS_ACC; w.ram_we = 1'b1; w.seq = SQ_FETCH; end
            5'd17: begin w.seq = SQ_FETCH; end
            default: begin w.seq = SQ_FETCH; end
        endcase
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] alu_eval(alu_op_e op, logic [WORD_W-1:0] a,
                                                   logic [WORD_W-1:0] b);
        case (op)
            ALU_ADD: return a + b;
            ALU_SUB: return a - b;
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
    import acc_cpu_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    output uword_t           mi
);
    always_comb mi = ucode_word(upc);
endmodule

// File: rtl/useq.sv
module useq
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_e             seq,
    input  logic [OPC_W-1:0] opc,
    output logic [UPC_W-1:0] upc,
    output logic             halted
);
    logic [UPC_W-1:0] upc_nx;

    always_comb begin
        case (seq)
            SQ_FETCH:    upc_nx = '0;
            SQ_DISPATCH: upc_nx = dispatch_base(opcode_e'(opc));
            SQ_HOLD:     upc_nx = upc;
            default:     upc_nx = upc + 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) upc <= '0;
        else     upc <= upc_nx;
    end

    assign halted = (seq == SQ_HOLD);

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9
    AST_FETCH_RESTART: assert property (@(posedge clk) disable iff (rst)
        (seq == SQ_FETCH) |=> (upc == '0)); // R3
endmodule

// File: rtl/dpath.sv
module dpath
    import acc_cpu_pkg::*;
#(
    parameter int RAM_AW = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  uword_t            mi,
    input  logic [WORD_W-1:0] ram_rd,
    output logic [WORD_W-1:0] bus,
    output logic [RAM_AW-1:0] mar,
    output logic [OPC_W-1:0]  ir_opc,
    output logic [WORD_W-1:0] acc,
    output logic [WORD_W-1:0] pc
);
    logic [WORD_W-1:0] ir, arg, bufr, alu_y;
    logic [WORD_W-1:0] srcval [NUM_SRC];
    logic [NUM_SRC-1:0] drv;

    assign alu_y = alu_eval(mi.alu, acc, arg);

    always_comb begin
        srcval[BS_NONE] = '0;
        srcval[BS_PC]   = pc;
        srcval[BS_ACC]  = acc;
        srcval[BS_IRA]  = {{OPC_W{1'b0}}, ir[AFLD_W-1:0]};
        srcval[BS_BUF]  = bufr;
        srcval[BS_ALU]  = alu_y;
        srcval[BS_RAM]  = ram_rd;
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_drv
        assign drv[k] = (mi.src == bus_src_e'(k));
    end

    always_comb begin
        bus = '0;
        for (int k = 1; k < NUM_SRC; k++)
            bus = bus | ({WORD_W{drv[k]}} & srcval[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            acc  <= '0;
            ir   <= '0;
            arg  <= '0;
            bufr <= '0;
            mar  <= '0;
        end else begin
            if (mi.ld_mar) mar  <= bus[RAM_AW-1:0];
            if (mi.ld_buf) bufr <= bus;
            if (mi.ld_ir)  ir   <= bus;
            if (mi.ld_arg) arg  <= bus;
            if (mi.ld_acc) acc  <= bus;
            if (mi.ld_pc || (mi.ld_pcz && acc == '0)) pc <= bus;
            else if (mi.pc_inc)                       pc <= pc + 1'b1;
        end
    end

    assign ir_opc = ir[WORD_W-1:AFLD_W];

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv[NUM_SRC-1:1])); // R10
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        mi.pc_inc |=> (pc == $past(pc) + 1'b1)); // R3
    AST_JZ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mi.ld_pcz && acc != '0) |=> (pc == $past(pc))); // R5
    AST_JZ_TAKE: assert property (@(posedge clk) disable iff (rst)
        (mi.ld_pcz && acc == '0) |=> (pc == $past(bus))); // R5
    AST_ACC_KEEP: assert property (@(posedge clk) disable iff (rst)
        !mi.ld_acc |=> $stable(acc)); // R8
endmodule

// File: rtl/wram.sv
module wram #(
    parameter int AW = 8,
    parameter int DW = 16
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int RAM_AW = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [RAM_AW-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] acc_q,
    output logic [WORD_W-1:0] pc_q,
    output logic              halted
);
    uword_t            mi;
    logic [UPC_W-1:0]  upc;
    logic [OPC_W-1:0]  ir_opc;
    logic [WORD_W-1:0] bus, ram_rd, wdata;
    logic [RAM_AW-1:0] mar, waddr;
    logic              we;

    ucode_rom u_rom (.upc(upc), .mi(mi));

    useq u_seq (
        .clk(clk), .rst(rst), .seq(mi.seq), .opc(ir_opc),
        .upc(upc), .halted(halted)
    );

    dpath #(.RAM_AW(RAM_AW)) u_dp (
        .clk(clk), .rst(rst), .mi(mi), .ram_rd(ram_rd), .bus(bus),
        .mar(mar), .ir_opc(ir_opc), .acc(acc_q), .pc(pc_q)
    );

    // program loading only while reset holds the sequencer
    assign we    = rst ? load_en   : mi.ram_we;
    assign waddr = rst ? load_addr : mar;
    assign wdata = rst ? load_data : bus;

    wram #(.AW(RAM_AW), .DW(WORD_W)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(mar), .rdata(ram_rd)
    );

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc_q) && $stable(acc_q))); // R9
    AST_STORE_FROM_ACC: assert property (@(posedge clk) disable iff (rst)
        mi.ram_we |-> (bus == acc_q)); // R10
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
    localparam int CLK_P  = 10;
    localparam int AW     = 8;
    localparam int DEPTH  = 1 << AW;
    localparam int LIMIT  = 4000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [15:0]   load_data = '0;
    logic [15:0]   acc_q, pc_q;
    logic          halted;

    int vectors = 0;
    int miscompares = 0;

    logic [15:0] img [DEPTH];
    logic [15:0] mm  [DEPTH];

    acc_cpu #(.RAM_AW(AW)) uut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .acc_q(acc_q), .pc_q(pc_q), .halted(halted)
    );

    always #(CLK_P/2) clk = ~clk;

    // R2 encoding: opcode in bits 15:13, address field in 12:0
    function automatic logic [15:0] enc(int op, int a);
        return {op[2:0], a[12:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        miscompares++;
        vectors++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    // instruction-level reference: fetch/decode 4 cycles, plus execute cycles
    task automatic model(output logic [15:0] eacc, output logic [15:0] epc, output int ecyc);
        logic [15:0] w;
        int op;
        logic [12:0] a;
        for (int i = 0; i < DEPTH; i++) mm[i] = img[i];
        eacc = 0; epc = 0; ecyc = 4;
        for (int s = 0; s < 1000; s++) begin
            w   = mm[epc[AW-1:0]];
            epc = epc + 16'd1;
            op  = int'(w[15:13]);
            a   = w[12:0];
            if (op == 0) break;
            case (op)
                1: begin epc = {3'b0, a}; ecyc += 5; end
                2: begin if (eacc == 0) epc = {3'b0, a}; ecyc += 5; end
                3: begin eacc = eacc + mm[a[AW-1:0]]; ecyc += 7; end
                4: begin eacc = eacc - mm[a[AW-1:0]]; ecyc += 7; end
                5: begin eacc = mm[a[AW-1:0]]; ecyc += 6; end
                6: begin mm[a[AW-1:0]] = eacc; ecyc += 6; end
                default: ecyc += 5;
            endcase
        end
    endtask

    task automatic run_prog(string tag, bit poke, logic [AW-1:0] paddr, logic [15:0] pdata);
        logic [15:0] eacc, epc, hacc, hpc;
        int ecyc, n;
        rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = AW'(i); load_data = img[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        chk({"R1 pc ", tag}, 32'(pc_q), 0);
        chk({"R1 acc ", tag}, 32'(acc_q), 0);
        chk({"R1 halted ", tag}, 32'(halted), 0);
        model(eacc, epc, ecyc);
        rst = 1'b0;
        n = 0;
        while (!halted && n < LIMIT) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 2) begin
                load_en = 1'b1; load_addr = paddr; load_data = pdata;
            end else begin
                load_en = 1'b0;
            end
        end
        load_en = 1'b0;
        chk({"R3 cycles ", tag}, 32'(n), 32'(ecyc));
        chk({"R6/R7 acc ", tag}, 32'(acc_q), 32'(eacc));
        chk({"R4/R5 pc ", tag}, 32'(pc_q), 32'(epc));
        hacc = acc_q; hpc = pc_q;
        repeat (8) @(negedge clk);
        chk({"R9 hold ", tag}, {15'd0, halted, acc_q ^ hacc}, {15'd0, 1'b1, 16'd0});
        chk({"R9 pc hold ", tag}, 32'(pc_q), 32'(hpc));
    endtask

    task automatic clear_img();
        for (int i = 0; i < DEPTH; i++) img[i] = 16'd0;
    endtask

    task automatic gen_random(int len);
        int k, t;
        clear_img();
        for (int i = 64; i < 80; i++) img[i] = 16'($urandom);
        for (int i = 0; i < len - 1; i++) begin
            k = int'($urandom % 7);
            case (k)
                0: begin
                    t = i + 1 + int'($urandom % 3);
                    if (t > len - 1) t = len - 1;
                    img[i] = enc(1, t);
                end
                1: begin
                    t = i + 1 + int'($urandom % 3);
                    if (t > len - 1) t = len - 1;
                    img[i] = enc(2, t);
                end
                // R11: random high address bits must be ignored by RAM selection
                default: img[i] = enc(k + 1, (int'($urandom % 32) << 8) + 64 + int'($urandom % 16));
            endcase
        end
        img[len - 1] = enc(0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R3/R9: stop at address 0
        clear_img();
        run_prog("halt-first", 1'b0, '0, '0);

        // R6: add wraps past 16 bits
        clear_img();
        img[0] = enc(5, 64); img[1] = enc(3, 65); img[2] = enc(0, 0);
        img[64] = 16'hFFFF; img[65] = 16'h0002;
        run_prog("R6 add-wrap", 1'b0, '0, '0);

        // R5/R6: subtract below zero, conditional jump not taken
        clear_img();
        img[0] = enc(4, 64); img[1] = enc(2, 5); img[2] = enc(0, 0); img[5] = enc(0, 0);
        img[64] = 16'h0001;
        run_prog("R5 jz-not-taken", 1'b0, '0, '0);

        // R5: conditional jump taken when accumulator is zero
        clear_img();
        img[0] = enc(2, 5); img[1] = enc(0, 0); img[5] = enc(5, 64); img[6] = enc(0, 0);
        img[64] = 16'h5A5A;
        run_prog("R5 jz-taken", 1'b0, '0, '0);

        // R7: store then load back
        clear_img();
        img[0] = enc(5, 64); img[1] = enc(6, 70); img[2] = enc(4, 64);
        img[3] = enc(5, 70); img[4] = enc(0, 0);
        img[64] = 16'h1357;
        run_prog("R7 store-load", 1'b0, '0, '0);

        // R4/R8: jump over, no-ops leave accumulator alone
        clear_img();
        img[0] = enc(5, 64); img[1] = enc(1, 10); img[2] = enc(0, 0);
        img[10] = enc(7, 0); img[11] = enc(7, 99); img[12] = enc(0, 0);
        img[64] = 16'h00C3;
        run_prog("R8 jmp-nop", 1'b0, '0, '0);

        // R11: load-port write while running is ignored; masked address field
        clear_img();
        img[0] = enc(7, 0); img[1] = enc(7, 0); img[2] = enc(5, 13'h1F40); img[3] = enc(0, 0);
        img[64] = 16'h1234;
        run_prog("R11 load-ignored", 1'b1, AW'(64), 16'hBEEF);

        // R2: random programs through the whole opcode set
        for (int r = 0; r < 20; r++) begin
            gen_random(8 + int'($urandom % 20));
            run_prog("R2 random", 1'b0, '0, '0);
        end

        summary();
    end
endmodule